// File: doc/BRIEF.md
# Command-Driven Sensor SPI Slave

This block is the serial front end of a sensor device. An external controller selects it by pulling an active-low select line low. The controller then clocks in an 8-bit command on MOSI, most significant bit first. The command fixes what the rest of the transaction does. It can return the latest sensor sample, return the status byte, deliver an address and a data byte to the core's register file, or do nothing. While the command is being received, the status byte is already clocked out on MISO.

The select, serial clock and data inputs are sampled by the system clock. Edges are found by comparing each input with its value one cycle earlier, so SCK must stay well below the system clock rate. MOSI is taken on rising SCK and MISO moves on falling SCK (SPI mode 0). An unknown command puts MISO in high impedance and makes the block deaf to MOSI until the next selection. Releasing select clears all transaction state.

Top module: `sensorSpiSlave`

## Requirements
- R1: Out of reset, and whenever select (csN) is high, misoOe is 0 (MISO in high impedance) and regWe is 0.
- R2: From the falling edge of csN, MISO drives the status byte as it stood at that edge, bit 7 first. MISO changes only at that edge and at falling SCK edges.
- R3: MOSI is taken on rising SCK edges, most significant bit first. The first 8 bits after selection form the command. Defined codes: 0x00 no-op, 0x10 read sample, 0x20 read status, 0x30 write register.
- R4: After command 0x10, the SAMPLE_W-bit sample is latched on the rising SCK edge that completes the command. Its MSB appears on MISO after the 8th falling edge, then the rest MSB first, then zeros. A change to the sample after that latch does not alter the returned bits.
- R5: After command 0x20, the status byte, re-read on the command's last rising edge, follows on MISO MSB first, then zeros.
- R6: After command 0x30, with no gap, the next 8 MOSI bits are the register address and the following 8 are the data. On the 24th rising edge, regWe pulses for exactly one cycle with regAddr and regWdata. MISO drives 0 during these bits.
- R7: A write whose address byte is NUM_REGS or greater produces no regWe pulse.
- R8: Command 0x00 drives MISO low for the rest of the transaction and never pulses regWe.
- R9: Any other command drops misoOe after its 8th rising edge. Until csN falls again, further MOSI bits are ignored, so no regWe pulse follows even if they form a write frame. The next selection decodes a new command normally.
- R10: A rising csN aborts the transaction and clears the bit count and command. A write cut short before its 24th bit produces no regWe, and the next transaction starts a fresh command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial inputs are sampled on it |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low select from the serial controller |
| sck | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out; high impedance when misoOe is 0 |
| misoOe | output | 1 | High while the block drives MISO |
| sample | input | SAMPLE_W | Current sensor sample from the core |
| status | input | 8 | Current status byte from the core |
| regWe | output | 1 | One-cycle register write strobe |
| regAddr | output | $clog2(NUM_REGS) | Register index for the write |
| regWdata | output | 8 | Register write data |

## Verification
The bench builds the block with SAMPLE_W of 11 and NUM_REGS of 6. Because 6 is not a power of two, addresses 6 and 7 fit in the 3-bit index but must still be rejected. A range check that only truncates the address byte would therefore be caught. An 11-bit sample is wider than the status byte, so the alignment of the output shift register is exercised on both its short and its long loads.

// File: rtl/spiSlvPkg.sv
package spiSlvPkg;

  localparam int BYTE_W = 8;

  typedef enum logic [7:0] {
    CMD_NOP       = 8'h00,
    CMD_RD_SAMPLE = 8'h10,
    CMD_RD_STATUS = 8'h20,
    CMD_WRITE     = 8'h30
  } cmd_e;

  typedef enum logic [1:0] {
    TAIL_ZERO   = 2'd0,
    TAIL_SAMPLE = 2'd1,
    TAIL_STATUS = 2'd2
  } tailSel_e;

  typedef struct packed {
    logic     loadHead;
    logic     loadTail;
    tailSel_e tailSel;
    logic     shiftIn;
    logic     shiftOut;
    logic     captureAddr;
    logic     commitWrite;
  } strobe_t;

  function automatic logic isKnownCmd(input logic [7:0] code);
    case (code)
      CMD_NOP, CMD_RD_SAMPLE, CMD_RD_STATUS, CMD_WRITE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/spiSlvCtrl.sv
module spiSlvCtrl
  import spiSlvPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              mosi,
  input  logic [BYTE_W-1:0] nextByte,
  output logic              mosiBit,
  output logic              misoOe,
  output strobe_t           st
);

  localparam int FRAME_BITS = 3 * BYTE_W;
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(2 * BYTE_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(FRAME_BITS);

  logic csQ, csP, sckQ, sckP, mosiQ;
  logic csFall, csRise, sckRise, sckFall;
  logic active, locked, cmdValid;
  cmd_e cmdReg;
  logic [CNT_W-1:0] bitCnt;
  logic cmdDone, cmdKnown, isWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ   <= 1'b1;
      csP   <= 1'b1;
      sckQ  <= 1'b0;
      sckP  <= 1'b0;
      mosiQ <= 1'b0;
    end else begin
      csQ   <= csN;
      csP   <= csQ;
      sckQ  <= sck;
      sckP  <= sckQ;
      mosiQ <= mosi;
    end
  end

  assign csFall  = csP & ~csQ;
  assign csRise  = ~csP & csQ;
  assign sckRise = sckQ & ~sckP;
  assign sckFall = ~sckQ & sckP;
  assign mosiBit = mosiQ;

  assign isWrite  = cmdValid && (cmdReg == CMD_WRITE);
  assign cmdKnown = isKnownCmd(nextByte);

  always_comb begin
    st = '0;
    st.loadHead    = csFall;
    st.shiftIn     = active && !locked && !csQ && sckRise && (bitCnt < CNT_MAX);
    st.shiftOut    = active && !locked && !csQ && sckFall;
    cmdDone        = st.shiftIn && (bitCnt == CMD_LAST);
    st.loadTail    = cmdDone && cmdKnown;
    case (nextByte)
      CMD_RD_SAMPLE: st.tailSel = TAIL_SAMPLE;
      CMD_RD_STATUS: st.tailSel = TAIL_STATUS;
      default:       st.tailSel = TAIL_ZERO;
    endcase
    st.captureAddr = st.shiftIn && isWrite && (bitCnt == ADDR_LAST);
    st.commitWrite = st.shiftIn && isWrite && (bitCnt == DATA_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      locked   <= 1'b0;
      cmdValid <= 1'b0;
      cmdReg   <= CMD_NOP;
      bitCnt   <= '0;
      misoOe   <= 1'b0;
    end else if (csRise || csFall) begin
      active   <= csFall;
      locked   <= 1'b0;
      cmdValid <= 1'b0;
      cmdReg   <= CMD_NOP;
      bitCnt   <= '0;
      misoOe   <= csFall;
    end else if (st.shiftIn) begin
      bitCnt <= bitCnt + 1'b1;
      if (cmdDone) begin
        if (cmdKnown) begin
          cmdValid <= 1'b1;
          cmdReg   <= cmd_e'(nextByte);
        end else begin
          locked <= 1'b1;
          misoOe <= 1'b0;
        end
      end
    end
  end

  assert_idle_hiz_R1: assert property (@(posedge clk) disable iff (!rstN)
    (csQ && csP) |-> !misoOe);

  assert_cnt_limit_R3: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_MAX);

  assert_lock_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> (!misoOe && !st.shiftIn && !st.commitWrite));

  assert_abort_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    csRise |=> (bitCnt == '0 && !cmdValid && !locked && !active));

endmodule

// File: rtl/spiSlvData.sv
module spiSlvData
  import spiSlvPkg::*;
#(
  parameter int SAMPLE_W = 11,
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             st,
  input  logic                mosiBit,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [BYTE_W-1:0]   status,
  output logic [BYTE_W-1:0]   nextByte,
  output logic                outBit,
  output logic                regWe,
  output logic [IDX_W-1:0]    regAddr,
  output logic [BYTE_W-1:0]   regWdata
);

  localparam int SHIFT_W = (SAMPLE_W > BYTE_W) ? SAMPLE_W : BYTE_W;
  localparam logic [BYTE_W-1:0] REG_LIMIT = BYTE_W'(NUM_REGS);

  logic [BYTE_W-1:0]  inShift;
  logic [BYTE_W-1:0]  addrReg;
  logic [SHIFT_W-1:0] outShift;
  logic [SHIFT_W-1:0] tailWord;

  assign nextByte = {inShift[BYTE_W-2:0], mosiBit};

  always_comb begin
    case (st.tailSel)
      TAIL_SAMPLE: tailWord = SHIFT_W'(sample) << (SHIFT_W - SAMPLE_W);
      TAIL_STATUS: tailWord = SHIFT_W'(status) << (SHIFT_W - BYTE_W);
      default:     tailWord = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inShift <= '0;
    end else if (st.shiftIn) begin
      inShift <= nextByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outBit   <= 1'b0;
      outShift <= '0;
    end else if (st.loadHead) begin
      outBit   <= status[BYTE_W-1];
      outShift <= SHIFT_W'(status) << (SHIFT_W - BYTE_W + 1);
    end else if (st.loadTail) begin
      outShift <= tailWord;
    end else if (st.shiftOut) begin
      outBit   <= outShift[SHIFT_W-1];
      outShift <= outShift << 1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      regWe    <= 1'b0;
      regAddr  <= '0;
      regWdata <= '0;
    end else begin
      regWe <= 1'b0;
      if (st.captureAddr) begin
        addrReg <= nextByte;
      end
      if (st.commitWrite && (addrReg < REG_LIMIT)) begin
        regWe    <= 1'b1;
        regAddr  <= addrReg[IDX_W-1:0];
        regWdata <= nextByte;
      end
    end
  end

  assert_we_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> (32'(regAddr) < NUM_REGS));

  assert_we_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe);

  assert_out_edge_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(outBit) |-> $past(st.shiftOut || st.loadHead));

endmodule

// File: rtl/sensorSpiSlave.sv
module sensorSpiSlave
  import spiSlvPkg::*;
#(
  parameter int SAMPLE_W = 11,
  parameter int NUM_REGS = 4,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                sck,
  input  logic                mosi,
  output logic                miso,
  output logic                misoOe,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [7:0]          status,
  output logic                regWe,
  output logic [IDX_W-1:0]    regAddr,
  output logic [7:0]          regWdata
);

  strobe_t           st;
  logic              mosiBit;
  logic              outBit;
  logic [BYTE_W-1:0] nextByte;

  spiSlvCtrl ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .sck      (sck),
    .mosi     (mosi),
    .nextByte (nextByte),
    .mosiBit  (mosiBit),
    .misoOe   (misoOe),
    .st       (st)
  );

  spiSlvData #(
    .SAMPLE_W (SAMPLE_W),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) data (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .mosiBit  (mosiBit),
    .sample   (sample),
    .status   (status),
    .nextByte (nextByte),
    .outBit   (outBit),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata)
  );

  assign miso = misoOe ? outBit : 1'bz;

endmodule

// File: tb/sensorSpiSlave_test.sv
`timescale 1ns/1ps
module sensorSpiSlave_test;

  localparam int SW = 11;
  localparam int NR = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic [SW-1:0] sampleIn = '0;
  logic [7:0] statusIn = '0;
  wire  miso;
  logic misoOe;
  logic regWe;
  logic [2:0] regAddr;
  logic [7:0] regWdata;

  int tests = 0;
  int fails = 0;
  int weCount = 0;
  logic [2:0] lastAddr;
  logic [7:0] lastData;

  always #2.5 clk = ~clk;

  sensorSpiSlave #(.SAMPLE_W(SW), .NUM_REGS(NR)) uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi),
    .miso(miso), .misoOe(misoOe), .sample(sampleIn), .status(statusIn),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata)
  );

  always @(negedge clk) begin
    if (regWe) begin
      weCount++;
      lastAddr = regAddr;
      lastData = regWdata;
    end
  end

  function automatic logic known(input logic [7:0] c);
    return c == 8'h00 || c == 8'h10 || c == 8'h20 || c == 8'h30;
  endfunction

  function automatic logic expBit(input logic [7:0] c, input int i,
                                  input logic [7:0] s, input logic [SW-1:0] smp);
    if (i < 8) return s[7-i];
    if (c == 8'h10) return (i - 8 < SW) ? smp[SW-1-(i-8)] : 1'b0;
    if (c == 8'h20) return (i - 8 < 8) ? s[7-(i-8)] : 1'b0;
    return 1'b0;
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One transaction: nBits SCK cycles, command then payload (addr, data).
  task automatic xfer(input logic [7:0] c, input logic [15:0] payload,
                      input int nBits, input int chgIdx, input logic [SW-1:0] chgVal,
                      input string req);
    logic [7:0] stAtFall;
    logic [SW-1:0] smpUsed;
    int expWe;
    int weBefore;
    int badBit;
    logic badAct, badExp, badOe;
    stAtFall = statusIn;
    smpUsed  = (chgIdx >= 0 && chgIdx < 7) ? chgVal : sampleIn;
    expWe = (c == 8'h30 && nBits >= 24 && payload[15:8] < NR) ? 1 : 0;
    weBefore = weCount;
    badBit = -1; badAct = 0; badExp = 0; badOe = 0;
    csN = 1'b0;
    waitClk(4);
    for (int i = 0; i < nBits; i++) begin
      if (i < 8) mosi = c[7-i];
      else if (i < 24) mosi = payload[15-(i-8)];
      else mosi = 1'($urandom);
      waitClk(4);
      begin
        logic eo, eb;
        eo = known(c) || i < 8;
        eb = expBit(c, i, stAtFall, smpUsed);
        if (badBit < 0 && (misoOe !== eo || (eo && miso !== eb))) begin
          badBit = i; badAct = miso; badExp = eb; badOe = misoOe;
        end
      end
      sck = 1'b1;
      waitClk(4);
      if (i == chgIdx) sampleIn = chgVal;
      sck = 1'b0;
    end
    waitClk(4);
    check(badBit < 0, req, $sformatf("miso stream cmd %h bit %0d oe %0d", c, badBit, badOe),
          badAct, badExp);
    csN = 1'b1;
    waitClk(4);
    check(weCount - weBefore == expWe, req, "write strobe count", weCount - weBefore, expWe);
    if (expWe == 1) begin
      check(lastAddr == payload[10:8], req, "write addr", lastAddr, payload[10:8]);
      check(lastData == payload[7:0], req, "write data", lastData, payload[7:0]);
    end
    check(misoOe === 1'b0, "R1", "oe after deselect", misoOe, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    waitClk(3);
    check(misoOe === 1'b0, "R1", "oe in reset", misoOe, 0);
    rstN = 1'b1;
    waitClk(4);
    check(misoOe === 1'b0 && regWe === 1'b0, "R1", "oe/we after reset", misoOe, 0);

    // R2/R4: status head then sample, coherency of latched sample
    statusIn = 8'hA5; sampleIn = 11'h5B3;
    xfer(8'h10, 16'h0, 24, 7, 11'h2CC, "R4 latch");
    sampleIn = 11'h1F0;
    xfer(8'h10, 16'h0, 22, 3, 11'h64A, "R4 early change");
    statusIn = 8'h3C;
    xfer(8'h20, 16'h0, 20, -1, '0, "R5 R2");
    xfer(8'h00, 16'hFFFF, 24, -1, '0, "R8");
    // R6/R7 boundaries
    xfer(8'h30, 16'h05_9E, 24, -1, '0, "R6 addr5");
    xfer(8'h30, 16'h00_00, 24, -1, '0, "R6 addr0");
    xfer(8'h30, 16'h06_77, 24, -1, '0, "R7 addr6");
    xfer(8'h30, 16'h07_11, 24, -1, '0, "R7 addr7");
    xfer(8'h30, 16'h82_11, 24, -1, '0, "R7 addr130");
    // R9: lockout, then normal restart
    xfer(8'h31, 16'h02_44, 26, -1, '0, "R9 lock");
    xfer(8'hFF, 16'h30_01, 24, -1, '0, "R9 lock");
    xfer(8'h30, 16'h02_44, 24, -1, '0, "R9 restart");
    // R10: aborted write and aborted command
    xfer(8'h30, 16'h03_5A, 20, -1, '0, "R10 abort write");
    xfer(8'h30, 16'h0, 4, -1, '0, "R10 abort cmd");
    xfer(8'h20, 16'h0, 16, -1, '0, "R10 fresh");
    // R3 and mixed random traffic
    for (int k = 0; k < 60; k++) begin
      logic [7:0] c;
      int pick;
      pick = $urandom_range(0, 4);
      case (pick)
        0: c = 8'h00; 1: c = 8'h10; 2: c = 8'h20; 3: c = 8'h30;
        default: c = 8'($urandom);
      endcase
      statusIn = 8'($urandom);
      sampleIn = SW'($urandom);
      xfer(c, {5'd0, 3'($urandom), 8'($urandom)}, $urandom_range(8, 28),
           -1, '0, "R3 random");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule